// File: doc/BRIEF.md
# Fair-Share Sub-Channel Switch Allocator

This block is the switch allocator of a five-port mesh router whose output links are wider than one flit. Each output link is cut into flit-wide sub-channels, and every virtual channel (VC) index owns the sub-channel of the same index on every output. Because VCs of one input port are bound to different sub-channels, they never compete with each other. Several VCs of one port can therefore send a flit each in the same cycle, and no input-side VC arbitration stage exists. Contention arises only between the same-numbered VCs of different input ports that head for the same output. Each output sub-channel settles it with its own round-robin arbiter.

Each VC presents a request valid bit and the output port that its head flit is routed to. One cycle later the allocator returns a one-hot grant vector per output sub-channel, naming the winning input port, and a one-cycle send pulse per VC. The per-VC pair `req_valid` / `vc_send` follows valid/ready rules with a one-cycle registered acceptance:
- Every cycle in which `req_valid` is high counts as a request for one flit.
- A `vc_send` pulse in the next cycle means that flit leaves.
- If no pulse follows, the request was not taken, and the requester keeps `req_valid` high for as long as it still has a flit.

A sub-channel whose VC has nothing to send stays idle; no other VC may use it. When `SUBCH_PER_VC` is above one, a VC index owns that many adjacent sub-channels. Up to that many ports' same-numbered VCs are then served together, and each VC still sends at most one flit. Downstream buffer space is assumed to be always available.

Top module: `subch_switch_alloc`

## Requirements
- R1: While `rst_n` is low, every bit of `sub_grant` and `vc_send` is 0, and every arbiter's priority starts at input port 0.
- R2: A request sampled at a rising edge produces its grant and its `vc_send` pulse in the cycle after that edge. No send occurs without a request in the previous cycle. A request held for one cycle only gives a pulse exactly one cycle long.
- R3: VC k of input port p (flat index p*NUM_VCS+k) is served only on sub-channels k*SUBCH_PER_VC to k*SUBCH_PER_VC+SUBCH_PER_VC-1 of its requested output. The grant bit for output o, sub-channel s, input p sits at `sub_grant` bit (o*NUM_VCS*SUBCH_PER_VC+s)*NUM_PORTS+p.
- R4: VCs of the same input port never block each other. All NUM_VCS VCs of one port that request the same output are all sent in the same cycle. A VC receives at most one grant per cycle.
- R5: Each sub-channel grants at most one input port per cycle.
- R6: Each sub-channel arbiter is round-robin over input ports. The highest priority goes to the port just past the last winner, wrapping from NUM_PORTS-1 to 0.
- R7: An arbiter's priority does not change in a cycle in which it issues no grant.
- R8: `req_port` values 0 to NUM_PORTS-1 select that output port. Any larger value makes no request on any sub-channel.
- R9: A VC with `req_valid` low makes no request, whatever its `req_port` holds.
- R10: Different outputs, and different sub-channels of one output, arbitrate independently in the same cycle.
- R11: A sub-channel whose bound VC has no request stays idle, even while other VCs of the same ports are losing arbitration on the same output.
- R12: With SUBCH_PER_VC above one, the lowest sub-channel of a VC's group takes the round-robin winner among the requesting ports. Each next sub-channel takes its own round-robin winner among the ports not yet granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NUM_PORTS*NUM_VCS | Per-VC request; bit p*NUM_VCS+k is VC k of input p |
| req_port | input | NUM_PORTS*NUM_VCS*PORT_W | Per-VC requested output port, PORT_W bits per VC at the same flat index |
| vc_send | output | NUM_PORTS*NUM_VCS | Per-VC one-flit send pulse, one cycle after the accepted request |
| sub_grant | output | NUM_PORTS*NUM_PORTS*NUM_VCS*SUBCH_PER_VC | One-hot winning input port for each output sub-channel |

## Verification
The bench builds two copies of the allocator. The first uses five ports, four VCs and one sub-channel per VC, which brings in reach the mesh case: all four VCs of one port sending together, the round-robin order across a three-way contention including the wrap from port 4 to port 0, the hold of a pointer across idle cycles, and the out-of-range route codes 5 to 7. The second uses three ports, two VCs and two sub-channels per VC. This is the only way to show a VC index owning a pair of sub-channels, with the chained pick of two winners and the third port left waiting.

// File: rtl/subch_alloc_pkg.sv
package subch_alloc_pkg;

  // Width of an index able to address n items (never below one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Flat bit position of one grant bit: output o, sub-channel s, input p.
  function automatic int unsigned grant_bit(input int unsigned o,
                                            input int unsigned s,
                                            input int unsigned p,
                                            input int unsigned n_sub,
                                            input int unsigned n_ports);
    return ((o * n_sub) + s) * n_ports + p;
  endfunction

endpackage

// File: rtl/subch_rr_arb.sv
// Round-robin N:1 arbiter. Combinational pick, priority pointer that moves
// to just past the winner only in a cycle that issues a grant.
module subch_rr_arb
  import subch_alloc_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  localparam int unsigned PTR_W = idx_width(N);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] win;
  logic [PTR_W-1:0] cand;
  logic             hit;

  always_comb begin
    gnt  = '0;
    hit  = 1'b0;
    win  = '0;
    cand = '0;
    for (int unsigned i = 0; i < N; i++) begin
      cand = PTR_W'((32'(ptr_q) + i) % N);
      if (!hit && req[cand]) begin
        hit       = 1'b1;
        win       = cand;
        gnt[cand] = 1'b1;
      end
    end
  end

  // Pointer advances past the winner, wrapping at N; held when idle (R7).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (hit) begin
      ptr_q <= ((32'(win) + 1) == N) ? '0 : PTR_W'(32'(win) + 1);
    end
  end

endmodule

// File: rtl/subch_req_decode.sv
// Turns per-VC (valid, route) pairs into per-output, per-VC-index request
// vectors over the input ports. Bit ((o*V)+k)*P+p is VC k of input p asking
// for output o. Out-of-range routes and invalid VCs request nothing.
module subch_req_decode #(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned NUM_VCS   = 4,
  parameter int unsigned PORT_W    = 3
) (
  input  logic [NUM_PORTS*NUM_VCS-1:0]           req_valid,
  input  logic [NUM_PORTS*NUM_VCS*PORT_W-1:0]    req_port,
  output logic [NUM_PORTS*NUM_VCS*NUM_PORTS-1:0] req_mat
);

  always_comb begin
    req_mat = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int k = 0; k < NUM_VCS; k++) begin
        for (int o = 0; o < NUM_PORTS; o++) begin
          if (req_valid[p*NUM_VCS+k] &&
              req_port[(p*NUM_VCS+k)*PORT_W +: PORT_W] == PORT_W'(o)) begin
            req_mat[((o*NUM_VCS)+k)*NUM_PORTS+p] = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/subch_lane_alloc.sv
// Allocation for the group of sub-channels bound to one VC index on one
// output. A chain of round-robin arbiters: each later sub-channel picks among
// the ports the earlier ones left. Grants are registered.
module subch_lane_alloc #(
  parameter int unsigned NUM_PORTS    = 5,
  parameter int unsigned SUBCH_PER_VC = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS-1:0]              req,
  output logic [SUBCH_PER_VC*NUM_PORTS-1:0] gnt_q
);

  logic [SUBCH_PER_VC-1:0][NUM_PORTS-1:0] pool;
  logic [SUBCH_PER_VC-1:0][NUM_PORTS-1:0] pick;

  assign pool[0] = req;

  for (genvar j = 0; j < SUBCH_PER_VC; j++) begin : g_sub
    subch_rr_arb #(.N(NUM_PORTS)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (pool[j]),
      .gnt  (pick[j])
    );
    if (j + 1 < SUBCH_PER_VC) begin : g_next
      assign pool[j+1] = pool[j] & ~pick[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
    end else begin
      gnt_q <= pick;
    end
  end

endmodule

// File: rtl/subch_switch_alloc.sv
// Single-stage fair-share switch allocator: one round-robin arbiter per
// output sub-channel, VC index k bound to sub-channel group k of every output.
module subch_switch_alloc
  import subch_alloc_pkg::*;
#(
  parameter int unsigned NUM_PORTS    = 5,
  parameter int unsigned NUM_VCS      = 4,
  parameter int unsigned SUBCH_PER_VC = 1,
  localparam int unsigned PORT_W      = idx_width(NUM_PORTS),
  localparam int unsigned NUM_SUBCH   = NUM_VCS * SUBCH_PER_VC,
  localparam int unsigned TOTAL_VC    = NUM_PORTS * NUM_VCS,
  localparam int unsigned GRANT_W     = NUM_PORTS * NUM_SUBCH * NUM_PORTS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TOTAL_VC-1:0]        req_valid,
  input  logic [TOTAL_VC*PORT_W-1:0] req_port,
  output logic [TOTAL_VC-1:0]        vc_send,
  output logic [GRANT_W-1:0]         sub_grant
);

  localparam int unsigned LANE_W = SUBCH_PER_VC * NUM_PORTS;

  logic [TOTAL_VC*NUM_PORTS-1:0] req_mat;
  logic [TOTAL_VC-1:0]           send_c;

  subch_req_decode #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_VCS  (NUM_VCS),
    .PORT_W   (PORT_W)
  ) u_decode (
    .req_valid(req_valid),
    .req_port (req_port),
    .req_mat  (req_mat)
  );

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    for (genvar k = 0; k < NUM_VCS; k++) begin : g_vc
      logic [NUM_PORTS-1:0] lane_req;
      logic [LANE_W-1:0]    lane_gnt;

      assign lane_req = req_mat[((o*NUM_VCS)+k)*NUM_PORTS +: NUM_PORTS];

      subch_lane_alloc #(
        .NUM_PORTS   (NUM_PORTS),
        .SUBCH_PER_VC(SUBCH_PER_VC)
      ) u_lane (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (lane_req),
        .gnt_q(lane_gnt)
      );

      assign sub_grant[((o*NUM_SUBCH)+k*SUBCH_PER_VC)*NUM_PORTS +: LANE_W] = lane_gnt;
    end
  end

  // A VC sends when any sub-channel in its group on any output granted it.
  always_comb begin
    send_c = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int k = 0; k < NUM_VCS; k++) begin
        for (int o = 0; o < NUM_PORTS; o++) begin
          for (int j = 0; j < SUBCH_PER_VC; j++) begin
            if (sub_grant[((o*NUM_SUBCH)+k*SUBCH_PER_VC+j)*NUM_PORTS+p]) begin
              send_c[p*NUM_VCS+k] = 1'b1;
            end
          end
        end
      end
    end
  end

  assign vc_send = send_c;

endmodule

// File: rtl/subch_switch_alloc_chk.sv
module subch_switch_alloc_chk #(
  parameter int unsigned NUM_PORTS    = 5,
  parameter int unsigned NUM_VCS      = 4,
  parameter int unsigned SUBCH_PER_VC = 1,
  parameter int unsigned PORT_W       = 3
) (
  input logic                                              clk,
  input logic                                              rst_n,
  input logic [NUM_PORTS*NUM_VCS-1:0]                      req_valid,
  input logic [NUM_PORTS*NUM_VCS*PORT_W-1:0]               req_port,
  input logic [NUM_PORTS*NUM_VCS-1:0]                      vc_send,
  input logic [NUM_PORTS*NUM_PORTS*NUM_VCS*SUBCH_PER_VC-1:0] sub_grant
);

  localparam int unsigned NSUB = NUM_VCS * SUBCH_PER_VC;
  localparam int unsigned TV   = NUM_PORTS * NUM_VCS;

  // Grants gathered per VC across all outputs and its bound sub-channels.
  logic [NUM_PORTS*SUBCH_PER_VC-1:0] vc_grants [TV];

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int k = 0; k < NUM_VCS; k++) begin
        vc_grants[p*NUM_VCS+k] = '0;
        for (int o = 0; o < NUM_PORTS; o++) begin
          for (int j = 0; j < SUBCH_PER_VC; j++) begin
            vc_grants[p*NUM_VCS+k][o*SUBCH_PER_VC+j] =
              sub_grant[((o*NSUB)+k*SUBCH_PER_VC+j)*NUM_PORTS+p];
          end
        end
      end
    end
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_o
    for (genvar s = 0; s < NSUB; s++) begin : g_s
      localparam int unsigned BASE = ((o*NSUB)+s)*NUM_PORTS;
      localparam int unsigned K    = s / SUBCH_PER_VC;

      assert_onehot_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sub_grant[BASE +: NUM_PORTS]));

      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
        // Grant only to the bound VC that asked for this output (R3, R11).
        assert_grant_routed_R8: assert property (@(posedge clk) disable iff (!rst_n)
          sub_grant[BASE+p] |->
            $past(req_valid[p*NUM_VCS+K] &&
                  req_port[(p*NUM_VCS+K)*PORT_W +: PORT_W] == PORT_W'(o)));
      end
    end
  end

  for (genvar i = 0; i < TV; i++) begin : g_vc
    assert_send_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vc_send[i] |-> $past(req_valid[i]));

    assert_single_flit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vc_grants[i]) <= 1);
  end

endmodule

bind subch_switch_alloc subch_switch_alloc_chk #(
  .NUM_PORTS   (NUM_PORTS),
  .NUM_VCS     (NUM_VCS),
  .SUBCH_PER_VC(SUBCH_PER_VC),
  .PORT_W      (PORT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_port (req_port),
  .vc_send  (vc_send),
  .sub_grant(sub_grant)
);

// File: tb/subch_switch_alloc_test.sv
`timescale 1ns/1ps
module subch_switch_alloc_test;

  localparam int P  = 5, V = 4, S = 1;
  localparam int PW = 3, NS = V*S, TV = P*V, GW = P*NS*P;
  localparam int WP = 3, WV = 2, WS = 2;
  localparam int WPW = 2, WNS = WV*WS, WTV = WP*WV, WGW = WP*WNS*WP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [TV-1:0]     req_valid = '0;
  logic [TV*PW-1:0]  req_port  = '0;
  logic [TV-1:0]     vc_send;
  logic [GW-1:0]     sub_grant;

  logic [WTV-1:0]     w_valid = '0;
  logic [WTV*WPW-1:0] w_port  = '0;
  logic [WTV-1:0]     w_send;
  logic [WGW-1:0]     w_grant;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  subch_switch_alloc #(.NUM_PORTS(P), .NUM_VCS(V), .SUBCH_PER_VC(S)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .vc_send(vc_send), .sub_grant(sub_grant));

  subch_switch_alloc #(.NUM_PORTS(WP), .NUM_VCS(WV), .SUBCH_PER_VC(WS)) uut_wide (
    .clk(clk), .rst_n(rst_n), .req_valid(w_valid), .req_port(w_port),
    .vc_send(w_send), .sub_grant(w_grant));

  function automatic int gbit(int o, int s, int p);
    return ((o*NS)+s)*P + p;
  endfunction

  function automatic int wbit(int o, int s, int p);
    return ((o*WNS)+s)*WP + p;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_req(int p, int k, int route);
    req_valid[p*V+k] = 1'b1;
    req_port[(p*V+k)*PW +: PW] = PW'(route);
  endtask

  task automatic clear_all();
    req_valid = '0;
    req_port  = '0;
    w_valid   = '0;
    w_port    = '0;
  endtask

  task automatic test_reset();
    check("R1 grants in reset", 128'(sub_grant), 128'(0));
    check("R1 sends in reset", 128'(vc_send), 128'(0));
    check("R1 wide grants in reset", 128'(w_grant), 128'(0));
  endtask

  task automatic test_single();
    logic [GW-1:0] eg;
    logic [TV-1:0] es;
    set_req(2, 1, 3);
    @(negedge clk);
    eg = '0; eg[gbit(3, 1, 2)] = 1'b1;
    es = '0; es[2*V+1] = 1'b1;
    check("R2/R3 single grant on out3 sub1", 128'(sub_grant), 128'(eg));
    check("R2 single send pulse", 128'(vc_send), 128'(es));
    clear_all();
    @(negedge clk);
    check("R2 pulse ends after one cycle", 128'(vc_send), 128'(0));
  endtask

  task automatic test_all_vcs();
    logic [GW-1:0] eg;
    for (int k = 0; k < V; k++) set_req(0, k, 0);
    @(negedge clk);
    eg = '0;
    for (int k = 0; k < V; k++) eg[gbit(0, k, 0)] = 1'b1;
    check("R4 all VCs of port0 granted", 128'(sub_grant), 128'(eg));
    check("R4 all VCs of port0 send", 128'(vc_send), 128'(TV'(4'hF)));
    clear_all();
    @(negedge clk);
  endtask

  task automatic test_round_robin();
    int order [4] = '{0, 1, 4, 0};
    set_req(0, 2, 1);
    set_req(1, 2, 1);
    set_req(4, 2, 1);
    for (int c = 0; c < 4; c++) begin
      logic [GW-1:0] eg;
      @(negedge clk);
      eg = '0; eg[gbit(1, 2, order[c])] = 1'b1;
      check($sformatf("R6 rr cycle %0d", c), 128'(sub_grant), 128'(eg));
      check($sformatf("R5 one winner cycle %0d", c), 128'($countones(sub_grant)), 128'(1));
    end
    clear_all();
    @(negedge clk);
  endtask

  task automatic test_hold_pointer();
    logic [GW-1:0] eg;
    set_req(3, 0, 2);
    @(negedge clk);
    eg = '0; eg[gbit(2, 0, 3)] = 1'b1;
    check("R6 lone port3 wins", 128'(sub_grant), 128'(eg));
    clear_all();
    repeat (3) @(negedge clk);
    set_req(0, 0, 2);
    set_req(4, 0, 2);
    @(negedge clk);
    eg = '0; eg[gbit(2, 0, 4)] = 1'b1;
    check("R7 pointer held over idle cycles", 128'(sub_grant), 128'(eg));
    clear_all();
    @(negedge clk);
  endtask

  task automatic test_idle_subch();
    logic [GW-1:0] eg;
    logic [TV-1:0] es;
    set_req(0, 0, 4);
    set_req(0, 1, 4);
    set_req(1, 0, 4);
    @(negedge clk);
    eg = '0; eg[gbit(4, 0, 0)] = 1'b1; eg[gbit(4, 1, 0)] = 1'b1;
    es = '0; es[0] = 1'b1; es[1] = 1'b1;
    check("R11 sub-channels 2,3 idle, loser waits", 128'(sub_grant), 128'(eg));
    check("R11 only port0 VCs send", 128'(vc_send), 128'(es));
    clear_all();
    @(negedge clk);
  endtask

  task automatic test_bad_route();
    set_req(0, 3, 5);
    set_req(2, 2, 7);
    set_req(4, 1, 6);
    @(negedge clk);
    check("R8 out-of-range route grants", 128'(sub_grant), 128'(0));
    check("R8 out-of-range route sends", 128'(vc_send), 128'(0));
    clear_all();
    @(negedge clk);
  endtask

  task automatic test_valid_low();
    req_port[(4*V+0)*PW +: PW] = 3'd1;
    req_port[(1*V+3)*PW +: PW] = 3'd0;
    @(negedge clk);
    check("R9 valid low grants", 128'(sub_grant), 128'(0));
    check("R9 valid low sends", 128'(vc_send), 128'(0));
    clear_all();
    @(negedge clk);
  endtask

  task automatic test_independent();
    logic [GW-1:0] eg;
    logic [TV-1:0] es;
    set_req(0, 0, 1);
    set_req(1, 0, 3);
    set_req(2, 3, 3);
    @(negedge clk);
    eg = '0; eg[gbit(1, 0, 0)] = 1'b1; eg[gbit(3, 0, 1)] = 1'b1; eg[gbit(3, 3, 2)] = 1'b1;
    es = '0; es[0] = 1'b1; es[1*V+0] = 1'b1; es[2*V+3] = 1'b1;
    check("R10 independent outputs and sub-channels", 128'(sub_grant), 128'(eg));
    check("R10 three sends", 128'(vc_send), 128'(es));
    clear_all();
    @(negedge clk);
  endtask

  task automatic test_wide();
    logic [WGW-1:0] eg;
    logic [WTV-1:0] es;
    for (int p = 0; p < WP; p++) begin
      w_valid[p*WV+1] = 1'b1;
      w_port[(p*WV+1)*WPW +: WPW] = 2'd2;
    end
    @(negedge clk);
    eg = '0; eg[wbit(2, 2, 0)] = 1'b1; eg[wbit(2, 3, 1)] = 1'b1;
    es = '0; es[0*WV+1] = 1'b1; es[1*WV+1] = 1'b1;
    check("R12 wide first cycle grants", 128'(w_grant), 128'(eg));
    check("R12 wide first cycle sends", 128'(w_send), 128'(es));
    @(negedge clk);
    eg = '0; eg[wbit(2, 2, 1)] = 1'b1; eg[wbit(2, 3, 2)] = 1'b1;
    es = '0; es[1*WV+1] = 1'b1; es[2*WV+1] = 1'b1;
    check("R12 wide second cycle grants", 128'(w_grant), 128'(eg));
    check("R12 wide second cycle sends", 128'(w_send), 128'(es));
    clear_all();
    @(negedge clk);
    check("R2 wide idle after clear", 128'(w_send), 128'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_single();
    test_all_vcs();
    test_round_robin();
    test_hold_pointer();
    test_idle_subch();
    test_bad_route();
    test_valid_low();
    test_independent();
    test_wide();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule